// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Front End

This block is the digital register front end of a four-channel converter with a parallel bus. A write places a code and a gain bit into the input register of one channel. The bus master selects the chip with an active-low select, presents a channel address, data and gain, and toggles an active-low write strobe. The write takes effect on the strobe's rising edge. A separate active-low load line moves the contents of the input registers into the DAC registers. The DAC registers feed the converter cores, so code and gain are both double-buffered.

A channel's DAC register copies its input register only if that input register has been written since the channel's last DAC update. This avoids needless output activity. Every channel carries a pending flag for this purpose. A write sets the flag, and a DAC load clears it.

A build-time option selects byte mode. In byte mode a 10-bit code is assembled from two bus writes, and a high-byte select input decides which half each write reaches. The bus pins are asynchronous to the system clock and pass through two-flop synchronizers. An active-low clear empties every register at once. Its release is synchronous.

Top module: `dac_load_ctrl`

## Requirements
- R1: After reset, every channel's DAC code and gain outputs are zero.
- R2: A write happens when chip select is low during the write strobe's low phase and the strobe then rises. Address 0..3 selects channel A..D. The channel's input register captures data and gain.
- R3: While the load line is high, no DAC code or gain output changes, even when input registers are written.
- R4: While the load line is low, each pending channel's DAC register copies its input register (code and gain). A single low pulse after several writes updates every written channel.
- R5: A channel whose input register was not written since its last DAC update keeps its DAC value when the load line is low.
- R6: A strobe edge with chip select high is ignored. The input register and the pending flag stay unchanged.
- R7: With the load line held low, a write reaches the DAC outputs within a few cycles of the strobe edge, with no load pulse.
- R8: Clear going low at once zeroes every input register, DAC register and pending flag. Registers come out of clear two clock edges after the release.
- R9: In byte mode, a write with high-byte select low stores data bits 7..0 as code bits 7..0. A write with it high stores data bits 1..0 as code bits 9..8, ignores data bits 7..2 and captures gain. A low-byte write leaves gain alone. Either write sets the pending flag, and the DAC loads the whole assembled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_ni | input | 1 | Active-low clear of all channel registers, asynchronous assert |
| cs_ni | input | 1 | Active-low chip select |
| wr_ni | input | 1 | Active-low write strobe, rising edge captures |
| ldac_ni | input | 1 | Active-low load of DAC registers |
| hben_i | input | 1 | High-byte select (byte mode only) |
| addr_i | input | 2 | Channel select, 0 = A .. 3 = D |
| data_i | input | 10 | Write data |
| gain_i | input | 1 | Gain bit to store |
| code_o | output | 40 | DAC codes, channel n in bits [10n+9:10n] |
| gain_o | output | 4 | DAC gain bits, bit n for channel n |

## Verification
The bench targets the places where double buffering can leak:
- **Writes with load high.** It checks that both code and gain stay frozen. A design that buffered only the code would show a gain change early.
- **Write qualification.** A pulse after a single write must leave the other channels alone, and a strobe without chip select must be dropped. A design that qualified writes wrongly would move the wrong channel.
- **Clear in byte mode.** A clear between a low-byte write and a high-byte write must empty the half-built input word. A design that cleared only the DAC registers would show stale low bits.
- **Byte assembly.** Junk placed in data bits 7..2 during a high-byte write must not reach the code.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned ADDR_W = $clog2(NUM_CH);

  // bus pin order inside the control synchronizer
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic ld_n;
    logic hben;
  } bus_ctrl_t;

  localparam bus_ctrl_t CTRL_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1, hben: 1'b0};
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[b] <= RST_VAL[b];
        s2_q[b] <= RST_VAL[b];
      end else begin
        s1_q[b] <= d_i[b];
        s2_q[b] <= s1_q[b];
      end
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dac_clr_sync.sv
module dac_clr_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  output logic regs_rst_no
);
  logic arst_n;
  logic [1:0] stage_q;

  assign arst_n = rst_ni & clr_ni;

  // assert immediately, release after two edges
  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign regs_rst_no = stage_q[1];
endmodule

// File: rtl/dac_bus_decode.sv
module dac_bus_decode
  import dac_load_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned DATA_W = CODE_W,
  parameter bit          BYTES  = 1'b0,
  localparam int unsigned AW    = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ns_i,
  input  logic              wr_ns_i,
  input  logic              hben_s_i,
  input  logic [AW-1:0]     addr_s_i,
  input  logic [DATA_W-1:0] data_s_i,
  input  logic              gain_s_i,
  output logic [N_CH-1:0]   wr_hit_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_gain_o,
  output logic              wr_hi_o
);
  logic wr_q, cs_q, wr_rise, wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b1;
      cs_q <= 1'b1;
    end else begin
      wr_q <= wr_ns_i;
      cs_q <= cs_ns_i;
    end
  end

  // select must be low through the strobe's low phase
  assign wr_rise = wr_ns_i & ~wr_q;
  assign wr_ok   = wr_rise & ~cs_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_hit
    assign wr_hit_o[c] = wr_ok && (addr_s_i == AW'(c));
  end

  assign wr_data_o = data_s_i;
  assign wr_gain_o = gain_s_i;
  assign wr_hi_o   = BYTES & hben_s_i;
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
  parameter int unsigned CODE_BITS = 10,
  parameter bit          BYTES     = 1'b0,
  localparam int unsigned HI_W     = CODE_BITS - 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_hit_i,
  input  logic [CODE_BITS-1:0] wr_data_i,
  input  logic                 wr_gain_i,
  input  logic                 wr_hi_i,
  input  logic                 load_i,
  output logic [CODE_BITS-1:0] code_o,
  output logic                 gain_o,
  output logic                 pend_o
);
  logic [CODE_BITS-1:0] in_code_q, in_code_d, dac_code_q;
  logic                 in_gain_q, dac_gain_q, pend_q, gain_we, do_load;

  always_comb begin
    if (BYTES) begin
      if (wr_hi_i) in_code_d = {wr_data_i[HI_W-1:0], in_code_q[7:0]};
      else         in_code_d = {in_code_q[CODE_BITS-1:8], wr_data_i[7:0]};
    end else begin
      in_code_d = wr_data_i;
    end
  end

  assign gain_we = BYTES ? wr_hi_i : 1'b1;
  assign do_load = load_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_code_q  <= '0;
      in_gain_q  <= 1'b0;
      dac_code_q <= '0;
      dac_gain_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      if (wr_hit_i) begin
        in_code_q <= in_code_d;
        if (gain_we) in_gain_q <= wr_gain_i;
      end
      if (do_load) begin
        dac_code_q <= in_code_q;
        dac_gain_q <= in_gain_q;
      end
      // a write in the load cycle stays pending
      if (wr_hit_i)     pend_q <= 1'b1;
      else if (do_load) pend_q <= 1'b0;
    end
  end

  assign code_o = dac_code_q;
  assign gain_o = dac_gain_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_load_pkg::*;
#(
  parameter int unsigned N_CH      = NUM_CH,
  parameter int unsigned CODE_BITS = CODE_W,
  parameter bit          BYTE_MODE = 1'b0,
  localparam int unsigned AW       = $clog2(N_CH),
  localparam int unsigned DSYNC_W  = AW + CODE_BITS + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_ni,
  input  logic                      cs_ni,
  input  logic                      wr_ni,
  input  logic                      ldac_ni,
  input  logic                      hben_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [CODE_BITS-1:0]      data_i,
  input  logic                      gain_i,
  output logic [N_CH*CODE_BITS-1:0] code_o,
  output logic [N_CH-1:0]           gain_o
);
  bus_ctrl_t              ctrl_raw, ctrl_s;
  logic [DSYNC_W-1:0]     dat_raw, dat_s;
  logic                   regs_rst_n, load;
  logic [N_CH-1:0]        wr_hit, pend;
  logic [CODE_BITS-1:0]   wr_data;
  logic                   wr_gain, wr_hi;

  assign ctrl_raw = '{cs_n: cs_ni, wr_n: wr_ni, ld_n: ldac_ni, hben: hben_i};
  assign dat_raw  = {addr_i, data_i, gain_i};

  dac_pin_sync #(.W($bits(bus_ctrl_t)), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
    .clk_i, .rst_ni, .d_i(ctrl_raw), .q_o(ctrl_s)
  );

  // data path delayed equally so it lines up with the strobe
  dac_pin_sync #(.W(DSYNC_W), .RST_VAL('0)) u_data_sync (
    .clk_i, .rst_ni, .d_i(dat_raw), .q_o(dat_s)
  );

  dac_clr_sync u_clr_sync (
    .clk_i, .rst_ni, .clr_ni, .regs_rst_no(regs_rst_n)
  );

  dac_bus_decode #(.N_CH(N_CH), .DATA_W(CODE_BITS), .BYTES(BYTE_MODE)) u_decode (
    .clk_i,
    .rst_ni    (regs_rst_n),
    .cs_ns_i   (ctrl_s.cs_n),
    .wr_ns_i   (ctrl_s.wr_n),
    .hben_s_i  (ctrl_s.hben),
    .addr_s_i  (dat_s[DSYNC_W-1 -: AW]),
    .data_s_i  (dat_s[CODE_BITS:1]),
    .gain_s_i  (dat_s[0]),
    .wr_hit_o  (wr_hit),
    .wr_data_o (wr_data),
    .wr_gain_o (wr_gain),
    .wr_hi_o   (wr_hi)
  );

  assign load = ~ctrl_s.ld_n;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dac_chan_reg #(.CODE_BITS(CODE_BITS), .BYTES(BYTE_MODE)) u_ch (
      .clk_i,
      .rst_ni    (regs_rst_n),
      .wr_hit_i  (wr_hit[c]),
      .wr_data_i (wr_data),
      .wr_gain_i (wr_gain),
      .wr_hi_i   (wr_hi),
      .load_i    (load),
      .code_o    (code_o[c*CODE_BITS +: CODE_BITS]),
      .gain_o    (gain_o[c]),
      .pend_o    (pend[c])
    );
  end
endmodule

// File: rtl/dac_load_ctrl_sva.sv
module dac_load_ctrl_sva #(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned CODE_BITS = 10
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      regs_rst_n,
  input logic                      load,
  input logic [N_CH-1:0]           wr_hit,
  input logic [N_CH-1:0]           pend,
  input logic [N_CH*CODE_BITS-1:0] code_o,
  input logic [N_CH-1:0]           gain_o
);
  a_r1_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regs_rst_n |-> (code_o == '0) && (gain_o == '0));

  a_r3_hold_outputs: assert property (@(posedge clk_i) disable iff (!regs_rst_n)
    !load |=> $stable(code_o) && $stable(gain_o));

  a_r2_single_target: assert property (@(posedge clk_i) disable iff (!regs_rst_n)
    $onehot0(wr_hit));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    a_r2_write_pends: assert property (@(posedge clk_i) disable iff (!regs_rst_n)
      wr_hit[c] |=> pend[c]);

    a_r4_load_retires: assert property (@(posedge clk_i) disable iff (!regs_rst_n)
      load && pend[c] && !wr_hit[c] |=> !pend[c]);

    a_r5_idle_keeps: assert property (@(posedge clk_i) disable iff (!regs_rst_n)
      !pend[c] |=> $stable(code_o[c*CODE_BITS +: CODE_BITS]) && $stable(gain_o[c]));
  end
endmodule

bind dac_load_ctrl dac_load_ctrl_sva #(.N_CH(N_CH), .CODE_BITS(CODE_BITS)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .regs_rst_n (regs_rst_n),
  .load       (load),
  .wr_hit     (wr_hit),
  .pend       (pend),
  .code_o     (code_o),
  .gain_o     (gain_o)
);

// File: tb/dac_load_ctrl_tb.sv
`timescale 1ns/1ps
module dac_load_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1, hben = 1'b0;
  logic [1:0] addr = '0;
  logic [CW-1:0] data = '0;
  logic gain = 1'b0;
  logic [NCH*CW-1:0] code_w, code_b;
  logic [NCH-1:0] gain_w, gain_b;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_load_ctrl #(.BYTE_MODE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .cs_ni(cs_n), .wr_ni(wr_n),
    .ldac_ni(ldac_n), .hben_i(hben), .addr_i(addr), .data_i(data), .gain_i(gain),
    .code_o(code_w), .gain_o(gain_w)
  );

  dac_load_ctrl #(.BYTE_MODE(1'b1)) dut_byte_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .cs_ni(cs_n), .wr_ni(wr_n),
    .ldac_ni(ldac_n), .hben_i(hben), .addr_i(addr), .data_i(data), .gain_i(gain),
    .code_o(code_b), .gain_o(gain_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int cw(input logic [NCH*CW-1:0] v, input int ch);
    return int'(v[ch*CW +: CW]);
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int ch, input int d, input bit g, input bit hi, input bit sel);
    @(negedge clk);
    addr = 2'(ch); data = CW'(d); gain = g; hben = hi; cs_n = ~sel;
    cycles(1); wr_n = 1'b0;
    cycles(3); wr_n = 1'b1;
    cycles(3); cs_n = 1'b1;
    cycles(2);
  endtask

  task automatic load_pulse();
    @(negedge clk); ldac_n = 1'b0;
    cycles(3); ldac_n = 1'b1;
    cycles(6);
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) begin
      chk("R1 code", cw(code_w, c), 0);
      chk("R1 code byte", cw(code_b, c), 0);
    end
    chk("R1 gain", int'(gain_w), 0);
  endtask

  task automatic t_hold_then_pulse();
    bus_write(0, 'h2AB, 1, 0, 1);
    bus_write(1, 'h155, 0, 0, 1);
    bus_write(2, 'h3FF, 1, 0, 1);
    cycles(4);
    chk("R3 codes frozen", int'(code_w[3*CW-1:0]), 0);
    chk("R3 gains frozen", int'(gain_w), 0);
    load_pulse();
    chk("R4 A", cw(code_w, 0), 'h2AB);
    chk("R4 B", cw(code_w, 1), 'h155);
    chk("R4 C", cw(code_w, 2), 'h3FF);
    chk("R2 D untouched", cw(code_w, 3), 0);
    chk("R4 gains", int'(gain_w), 'b0101);
  endtask

  task automatic t_selective();
    bus_write(3, 'h123, 1, 0, 1);
    load_pulse();
    chk("R5 D loaded", cw(code_w, 3), 'h123);
    chk("R5 A kept", cw(code_w, 0), 'h2AB);
    chk("R5 C kept", cw(code_w, 2), 'h3FF);
    load_pulse();
    chk("R5 repeat pulse", int'(code_w), int'({10'h123, 10'h3FF, 10'h155, 10'h2AB}));
    chk("R5 repeat gain", int'(gain_w), 'b1101);
    // gain held until load
    bus_write(0, 'h2AB, 0, 0, 1);
    cycles(4);
    chk("R3 gain frozen", int'(gain_w[0]), 1);
    load_pulse();
    chk("R4 gain loaded", int'(gain_w[0]), 0);
  endtask

  task automatic t_no_select();
    bus_write(0, 'h001, 1, 0, 0);
    load_pulse();
    chk("R6 A ignored", cw(code_w, 0), 'h2AB);
    chk("R6 gain ignored", int'(gain_w[0]), 0);
  endtask

  task automatic t_tied_low();
    @(negedge clk); ldac_n = 1'b0;
    cycles(3);
    bus_write(1, 'h077, 1, 0, 1);
    cycles(4);
    chk("R7 B first", cw(code_w, 1), 'h077);
    chk("R7 B gain", int'(gain_w[1]), 1);
    bus_write(1, 'h300, 0, 0, 1);
    cycles(4);
    chk("R7 B second", cw(code_w, 1), 'h300);
    chk("R7 B gain2", int'(gain_w[1]), 0);
    @(negedge clk); ldac_n = 1'b1;
    cycles(4);
  endtask

  task automatic t_clear();
    bus_write(2, 'h0AA, 1, 0, 1);
    @(negedge clk); clr_n = 1'b0;
    #1;
    chk("R8 async zero", int'(code_w), 0);
    cycles(2);
    chk("R8 zero byte", int'(code_b), 0);
    chk("R8 gains", int'(gain_w), 0);
    clr_n = 1'b1;
    cycles(4);
    load_pulse();
    chk("R8 pending dropped", int'(code_w), 0);
  endtask

  task automatic t_bytes();
    bus_write(0, 'h0CD, 0, 0, 1);
    bus_write(0, 'h0FE, 1, 1, 1); // bits 7..2 are junk
    cycles(4);
    chk("R3 byte frozen", cw(code_b, 0), 0);
    load_pulse();
    chk("R9 assembled", cw(code_b, 0), 'h2CD);
    chk("R9 gain hi", int'(gain_b[0]), 1);
    bus_write(0, 'h011, 0, 0, 1);
    load_pulse();
    chk("R9 low only", cw(code_b, 0), 'h211);
    chk("R9 gain kept", int'(gain_b[0]), 1);
    bus_write(1, 'h055, 0, 0, 1);
    @(negedge clk); clr_n = 1'b0;
    cycles(2); clr_n = 1'b1;
    cycles(4);
    bus_write(1, 'h003, 1, 1, 1);
    load_pulse();
    chk("R8 input cleared", cw(code_b, 1), 'h300);
    chk("R8 byte gain", int'(gain_b[1]), 1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_hold_then_pulse();
    t_selective();
    t_no_select();
    t_tied_low();
    t_clear();
    t_bytes();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule